// File: doc/BRIEF.md
# System Call and Interrupt Return Stage

This block is the combinational core of a 64-bit trap execution unit. It serves two micro-operations. The first is the system call. It sends the program to a fixed vector address and saves the address of the following instruction in the save/restore address register. It also saves a filtered copy of the machine state register (MSR) in the save/restore state register. The second is the return from interrupt. It resumes at the saved address with the two low bits cleared, and it rebuilds the MSR from the saved state under a set of guard rules.

Each result comes with its own ok flag, so the writeback logic around the block knows which architectural registers to update. A small context tag rides along unchanged. The block holds no state and has no clock. It sits between the pipeline registers of the trap unit, and those registers handle flow control. There is no valid/ready pair at this edge and no back-pressure rule: outputs follow the inputs in the same cycle, and a stall upstream simply holds the inputs steady.

Operation codes on `op_i` (width `OP_W`, default 2): 1 = system call, 2 = return from interrupt, any other value = idle. Bits are numbered LSB-0 throughout.

Top module: `trap_sysret_stage`

## Requirements
- R1: When `op_i` is 1 (system call), `nia_o` equals 0xC00 and `nia_ok_o` is 1.
- R2: When `op_i` is 1, `srr0_o` equals `cia_i + 4` modulo 2^64 (so 0xFFFF_FFFF_FFFF_FFFC gives 0) and `srr0_ok_o` is 1.
- R3: When `op_i` is 1, `srr1_o` equals `msr_i` with bits 16 to 21 and 27 to 30 cleared and all other bits copied, `srr1_ok_o` is 1, and `msr_ok_o` is 0.
- R4: When `op_i` is 2 (return from interrupt), `nia_o` equals `srr1`-independent `srr0_i` with bits 1:0 forced to 0, `nia_ok_o` is 1, and both `srr0_ok_o` and `srr1_ok_o` are 0.
- R5: When `op_i` is 2, `msr_o` bits 0 to 15, 22 to 26 and 31 to 63 come from `srr1_i`, bits 16 to 21 and 27 to 30 keep the value of `msr_i`, and `msr_ok_o` is 1. R6 and R7 override individual bits.
- R6: When `op_i` is 2 and `msr_i` bit 14 (problem state) is 1, `msr_o` bits 15 (external interrupt enable), 5 (instruction relocation) and 4 (data relocation) are 1 whatever `srr1_i` holds.
- R7: When `op_i` is 2, `msr_o[34:32]` (transaction state) equals `msr_i[34:32]` if that field is 3'b010 and `srr1_i[34:32]` is 3'b000. Otherwise it equals `srr1_i[34:32]`.
- R8: For any other `op_i` value, all four ok flags are 0 and `nia_o`, `srr0_o`, `srr1_o` and `msr_o` are 0.
- R9: `ctx_o` equals `ctx_i` for every operation code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | OP_W | Operation code: 1 system call, 2 return from interrupt, else idle |
| cia_i | input | 64 | Address of the current instruction |
| msr_i | input | 64 | Current machine state register |
| srr0_i | input | 64 | Saved return address register |
| srr1_i | input | 64 | Saved machine state register |
| ctx_i | input | CTX_W | Context tag carried alongside the operation |
| nia_o | output | 64 | Next instruction address |
| nia_ok_o | output | 1 | `nia_o` is to be written |
| srr0_o | output | 64 | New saved return address |
| srr0_ok_o | output | 1 | `srr0_o` is to be written |
| srr1_o | output | 64 | New saved machine state |
| srr1_ok_o | output | 1 | `srr1_o` is to be written |
| msr_o | output | 64 | New machine state register |
| msr_ok_o | output | 1 | `msr_o` is to be written |
| ctx_o | output | CTX_W | Context tag, unchanged |

## Verification
The bound checker re-evaluates its rules whenever an input settles. It covers the vector address, the address increment, the cleared ranges of the saved state, the low-bit clearing of the return address, the forced enables in problem state, the transaction-state guard, the idle outputs and the tag pass-through. It does not cover the full bit-level rebuild of the MSR on return across all of its ranges at once. The bench checks that against an independent model over a table of vectors and random values. Only the bench's directed cases show that address wrap-around and the near-miss transaction-state combinations (010 with 001, 011 with 000) take the restore path.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int XLEN = 64;

  // operation codes on the op input
  localparam int OPC_SYSCALL = 1;
  localparam int OPC_RETURN  = 2;

  // machine state bit positions (LSB-0)
  localparam int BIT_EXT_EN   = 15;
  localparam int BIT_PROBLEM  = 14;
  localparam int BIT_I_RELOC  = 5;
  localparam int BIT_D_RELOC  = 4;

  // transaction state field
  localparam int TS_LSB = 32;
  localparam int TS_W   = 3;
  localparam logic [TS_W-1:0] TS_CUR_HOLD  = 3'b010;
  localparam logic [TS_W-1:0] TS_SAVED_NIL = 3'b000;

  // partially implemented ranges that are never copied
  localparam int GAP_A_LO = 16;
  localparam int GAP_A_HI = 21;
  localparam int GAP_B_LO = 27;
  localparam int GAP_B_HI = 30;

  // one where a bit is fully implemented and copied between MSR and SRR1
  function automatic logic [XLEN-1:0] full_func_mask();
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) begin
      m[i] = !((i >= GAP_A_LO && i <= GAP_A_HI) ||
               (i >= GAP_B_LO && i <= GAP_B_HI));
    end
    return m;
  endfunction

endpackage

// File: rtl/trap_sc_path.sv
module trap_sc_path
  import trap_pkg::*;
#(
  parameter logic [XLEN-1:0] VECTOR = 64'h0000_0000_0000_0C00,
  parameter int              ILEN   = 4
) (
  input  logic [XLEN-1:0] cia,
  input  logic [XLEN-1:0] cur_msr,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] ret_addr,
  output logic [XLEN-1:0] saved_state
);

  localparam logic [XLEN-1:0] KEEP = full_func_mask();
  localparam logic [XLEN-1:0] STEP = XLEN'(ILEN);

  always_comb begin
    target      = VECTOR;
    ret_addr    = cia + STEP;  // wraps modulo 2^XLEN
    saved_state = cur_msr & KEEP;
  end

endmodule

// File: rtl/trap_rfid_path.sv
module trap_rfid_path
  import trap_pkg::*;
#(
  parameter int ALIGN_BITS = 2
) (
  input  logic [XLEN-1:0] cur_msr,
  input  logic [XLEN-1:0] saved_addr,
  input  logic [XLEN-1:0] saved_state,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] new_msr
);

  localparam logic [XLEN-1:0] KEEP       = full_func_mask();
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'((1 << ALIGN_BITS) - 1);

  logic [TS_W-1:0] cur_ts;
  logic [TS_W-1:0] sav_ts;
  logic            hold_ts;
  logic [XLEN-1:0] merged;

  assign cur_ts  = cur_msr[TS_LSB +: TS_W];
  assign sav_ts  = saved_state[TS_LSB +: TS_W];
  assign hold_ts = (cur_ts == TS_CUR_HOLD) && (sav_ts == TS_SAVED_NIL);

  always_comb begin
    target = saved_addr & ALIGN_MASK;
    merged = (saved_state & KEEP) | (cur_msr & ~KEEP);
    if (cur_msr[BIT_PROBLEM]) begin
      merged[BIT_EXT_EN]  = 1'b1;
      merged[BIT_I_RELOC] = 1'b1;
      merged[BIT_D_RELOC] = 1'b1;
    end
    if (hold_ts) begin
      merged[TS_LSB +: TS_W] = cur_ts;
    end
    new_msr = merged;
  end

endmodule

// File: rtl/trap_sysret_stage.sv
module trap_sysret_stage
  import trap_pkg::*;
#(
  parameter int              OP_W      = 2,
  parameter int              CTX_W     = 2,
  parameter logic [XLEN-1:0] SC_VECTOR = 64'h0000_0000_0000_0C00
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [XLEN-1:0]  cia_i,
  input  logic [XLEN-1:0]  msr_i,
  input  logic [XLEN-1:0]  srr0_i,
  input  logic [XLEN-1:0]  srr1_i,
  input  logic [CTX_W-1:0] ctx_i,
  output logic [XLEN-1:0]  nia_o,
  output logic             nia_ok_o,
  output logic [XLEN-1:0]  srr0_o,
  output logic             srr0_ok_o,
  output logic [XLEN-1:0]  srr1_o,
  output logic             srr1_ok_o,
  output logic [XLEN-1:0]  msr_o,
  output logic             msr_ok_o,
  output logic [CTX_W-1:0] ctx_o
);

  localparam logic [OP_W-1:0] CODE_SC  = OP_W'(OPC_SYSCALL);
  localparam logic [OP_W-1:0] CODE_RET = OP_W'(OPC_RETURN);

  logic            is_sc;
  logic            is_ret;
  logic [XLEN-1:0] sc_target;
  logic [XLEN-1:0] sc_ret_addr;
  logic [XLEN-1:0] sc_state;
  logic [XLEN-1:0] ret_target;
  logic [XLEN-1:0] ret_msr;

  assign is_sc  = (op_i == CODE_SC);
  assign is_ret = (op_i == CODE_RET);

  trap_sc_path #(
    .VECTOR (SC_VECTOR),
    .ILEN   (4)
  ) sc_u (
    .cia         (cia_i),
    .cur_msr     (msr_i),
    .target      (sc_target),
    .ret_addr    (sc_ret_addr),
    .saved_state (sc_state)
  );

  trap_rfid_path #(
    .ALIGN_BITS (2)
  ) ret_u (
    .cur_msr     (msr_i),
    .saved_addr  (srr0_i),
    .saved_state (srr1_i),
    .target      (ret_target),
    .new_msr     (ret_msr)
  );

  always_comb begin
    nia_o     = '0;
    nia_ok_o  = 1'b0;
    srr0_o    = '0;
    srr0_ok_o = 1'b0;
    srr1_o    = '0;
    srr1_ok_o = 1'b0;
    msr_o     = '0;
    msr_ok_o  = 1'b0;
    if (is_sc) begin
      nia_o     = sc_target;
      nia_ok_o  = 1'b1;
      srr0_o    = sc_ret_addr;
      srr0_ok_o = 1'b1;
      srr1_o    = sc_state;
      srr1_ok_o = 1'b1;
    end else if (is_ret) begin
      nia_o    = ret_target;
      nia_ok_o = 1'b1;
      msr_o    = ret_msr;
      msr_ok_o = 1'b1;
    end
  end

  assign ctx_o = ctx_i;

endmodule

// File: rtl/trap_sysret_chk.sv
module trap_sysret_chk
  import trap_pkg::*;
#(
  parameter int              OP_W      = 2,
  parameter int              CTX_W     = 2,
  parameter logic [XLEN-1:0] SC_VECTOR = 64'h0000_0000_0000_0C00
) (
  input logic [OP_W-1:0]  op_i,
  input logic [XLEN-1:0]  cia_i,
  input logic [XLEN-1:0]  msr_i,
  input logic [XLEN-1:0]  srr0_i,
  input logic [XLEN-1:0]  srr1_i,
  input logic [CTX_W-1:0] ctx_i,
  input logic [XLEN-1:0]  nia_o,
  input logic             nia_ok_o,
  input logic [XLEN-1:0]  srr0_o,
  input logic             srr0_ok_o,
  input logic [XLEN-1:0]  srr1_o,
  input logic             srr1_ok_o,
  input logic [XLEN-1:0]  msr_o,
  input logic             msr_ok_o,
  input logic [CTX_W-1:0] ctx_o
);

  localparam logic [XLEN-1:0] GAPS = ~full_func_mask();

  logic sc_op;
  logic ret_op;
  logic known;
  logic [TS_W-1:0] ts_cur;
  logic [TS_W-1:0] ts_sav;

  assign sc_op  = (int'(op_i) == OPC_SYSCALL);
  assign ret_op = (int'(op_i) == OPC_RETURN);
  assign known  = !$isunknown({op_i, cia_i, msr_i, srr0_i, srr1_i, ctx_i});
  assign ts_cur = msr_i[TS_LSB +: TS_W];
  assign ts_sav = srr1_i[TS_LSB +: TS_W];

  always_comb begin
    if (known) begin
      if (sc_op) begin
        // R1
        sc_vector_chk: assert (nia_ok_o && nia_o == SC_VECTOR);
        // R2
        sc_link_chk: assert (srr0_ok_o && srr0_o == cia_i + 64'd4);
        // R3
        sc_gap_zero_chk: assert (srr1_ok_o && !msr_ok_o && (srr1_o & GAPS) == '0
                                 && (srr1_o | GAPS) == (msr_i | GAPS));
      end
      if (ret_op) begin
        // R4
        ret_align_chk: assert (nia_ok_o && !srr0_ok_o && !srr1_ok_o
                               && nia_o[1:0] == 2'b00 && nia_o[XLEN-1:2] == srr0_i[XLEN-1:2]);
        // R5
        ret_gap_keep_chk: assert (msr_ok_o && (msr_o & GAPS) == (msr_i & GAPS));
        // R6
        if (msr_i[BIT_PROBLEM]) begin
          ret_user_en_chk: assert (msr_o[BIT_EXT_EN] && msr_o[BIT_I_RELOC] && msr_o[BIT_D_RELOC]);
        end
        // R7
        if (ts_cur == 3'b010 && ts_sav == 3'b000) begin
          ret_ts_hold_chk: assert (msr_o[TS_LSB +: TS_W] == ts_cur);
        end else begin
          ret_ts_load_chk: assert (msr_o[TS_LSB +: TS_W] == ts_sav);
        end
      end
      if (!sc_op && !ret_op) begin
        // R8
        idle_quiet_chk: assert ($countones({nia_ok_o, srr0_ok_o, srr1_ok_o, msr_ok_o}) == 0
                                && (nia_o | srr0_o | srr1_o | msr_o) == '0);
      end
      // R9
      ctx_pass_chk: assert (ctx_o == ctx_i);
    end
  end

endmodule

bind trap_sysret_stage trap_sysret_chk #(
  .OP_W      (OP_W),
  .CTX_W     (CTX_W),
  .SC_VECTOR (SC_VECTOR)
) chk_i (.*);

// File: tb/trap_sysret_stage_tb.sv
module trap_sysret_stage_tb_top;

  localparam int OP_W  = 2;
  localparam int CTX_W = 2;
  localparam logic [63:0] FULLMASK = 64'hFFFF_FFFF_87C0_FFFF;

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] cia;
    logic [63:0] msr;
    logic [63:0] srr0;
    logic [63:0] srr1;
    logic [1:0]  ctx;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TBL [NVEC] = '{
    '{2'd1, 64'h0000_0000_1000_0000, 64'h8000_0000_0000_A032, 64'h0, 64'h0, 2'd0},
    '{2'd1, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5, 64'h7, 2'd3},
    '{2'd2, 64'h0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_4003, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1},
    '{2'd2, 64'h0, 64'hFFFF_FFFF_FFFF_BFFF, 64'hDEAD_BEEF_0000_1002, 64'h0000_0000_0000_0000, 2'd2},
    '{2'd2, 64'h0, 64'h0000_0000_0000_4000, 64'h0000_0000_0000_0C01, 64'h0000_0001_0000_0000, 2'd0},
    '{2'd0, 64'hFFFF_0000_FFFF_0000, 64'h1234_5678_0000_4000, 64'hFF, 64'hFF, 2'd3},
    '{2'd3, 64'h0000_0000_0000_1000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 64'hFFFF, 2'd1},
    '{2'd1, 64'h0000_0000_0000_0000, 64'h0000_0000_7FFF_0000, 64'h0, 64'h0, 2'd2}
  };

  logic              clk;
  logic [OP_W-1:0]   op_i;
  logic [63:0]       cia_i, msr_i, srr0_i, srr1_i;
  logic [CTX_W-1:0]  ctx_i;
  logic [63:0]       nia_o, srr0_o, srr1_o, msr_o;
  logic              nia_ok_o, srr0_ok_o, srr1_ok_o, msr_ok_o;
  logic [CTX_W-1:0]  ctx_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  trap_sysret_stage #(.OP_W(OP_W), .CTX_W(CTX_W)) dut_i (
    .op_i      (op_i),
    .cia_i     (cia_i),
    .msr_i     (msr_i),
    .srr0_i    (srr0_i),
    .srr1_i    (srr1_i),
    .ctx_i     (ctx_i),
    .nia_o     (nia_o),
    .nia_ok_o  (nia_ok_o),
    .srr0_o    (srr0_o),
    .srr0_ok_o (srr0_ok_o),
    .srr1_o    (srr1_o),
    .srr1_ok_o (srr1_ok_o),
    .msr_o     (msr_o),
    .msr_ok_o  (msr_ok_o),
    .ctx_o     (ctx_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    op_i   = v.op;
    cia_i  = v.cia;
    msr_i  = v.msr;
    srr0_i = v.srr0;
    srr1_i = v.srr1;
    ctx_i  = v.ctx;
    @(negedge clk);
  endtask

  // independent model of the requirements
  task automatic check_vec(input vec_t v);
    logic [63:0] m;
    apply(v);
    chk("R9", "ctx", 64'(ctx_o), 64'(v.ctx));
    if (v.op == 2'd1) begin
      chk("R1", "nia", nia_o, 64'hC00);
      chk("R1", "nia_ok", 64'(nia_ok_o), 64'd1);
      chk("R2", "srr0", srr0_o, v.cia + 64'd4);
      chk("R2", "srr0_ok", 64'(srr0_ok_o), 64'd1);
      chk("R3", "srr1", srr1_o, v.msr & FULLMASK);
      chk("R3", "srr1_ok/msr_ok", {62'd0, srr1_ok_o, msr_ok_o}, 64'd2);
    end else if (v.op == 2'd2) begin
      m = (v.srr1 & FULLMASK) | (v.msr & ~FULLMASK);
      if (v.msr[14]) m = m | 64'h8030;
      if (v.msr[34:32] == 3'b010 && v.srr1[34:32] == 3'b000) m[34:32] = 3'b010;
      chk("R4", "nia", nia_o, {v.srr0[63:2], 2'b00});
      chk("R4", "oks", {60'd0, nia_ok_o, srr0_ok_o, srr1_ok_o, 1'b0}, 64'h8);
      chk("R5", "msr (R6/R7 merged)", msr_o, m);
      chk("R5", "msr_ok", 64'(msr_ok_o), 64'd1);
    end else begin
      chk("R8", "oks", {60'd0, nia_ok_o, srr0_ok_o, srr1_ok_o, msr_ok_o}, 64'd0);
      chk("R8", "data", nia_o | srr0_o | srr1_o | msr_o, 64'd0);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    vec_t v;
    op_i = '0; cia_i = '0; msr_i = '0; srr0_i = '0; srr1_i = '0; ctx_i = '0;
    @(negedge clk);
    // R8 idle state after start-up
    chk("R8", "idle oks", {60'd0, nia_ok_o, srr0_ok_o, srr1_ok_o, msr_ok_o}, 64'd0);

    for (int i = 0; i < NVEC; i++) check_vec(TBL[i]);

    // R2 address wrap
    check_vec('{2'd1, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 64'h0, 64'h0, 2'd1});
    chk("R2", "wrap to zero", srr0_o, 64'd0);

    // R6 problem state forces enables over zero saved bits
    check_vec('{2'd2, 64'h0, 64'h0000_0000_0000_4000, 64'h100, 64'h0, 2'd0});
    chk("R6", "ee/ir/dr", {61'd0, msr_o[15], msr_o[5], msr_o[4]}, 64'd7);

    // R6 no forcing when not in problem state
    check_vec('{2'd2, 64'h0, 64'h0, 64'h100, 64'h0, 2'd0});
    chk("R6", "ee/ir/dr clear", {61'd0, msr_o[15], msr_o[5], msr_o[4]}, 64'd0);

    // R7 hold case and near misses
    check_vec('{2'd2, 64'h0, 64'h0000_0002_0000_0000, 64'h0, 64'h0, 2'd0});
    chk("R7", "ts held", 64'(msr_o[34:32]), 64'd2);
    check_vec('{2'd2, 64'h0, 64'h0000_0002_0000_0000, 64'h0, 64'h0000_0001_0000_0000, 2'd0});
    chk("R7", "ts from saved 001", 64'(msr_o[34:32]), 64'd1);
    check_vec('{2'd2, 64'h0, 64'h0000_0003_0000_0000, 64'h0, 64'h0, 2'd0});
    chk("R7", "ts from saved 000", 64'(msr_o[34:32]), 64'd0);

    // R3 / R5 gap ranges in isolation
    check_vec('{2'd1, 64'h40, 64'h0000_0000_783F_0000, 64'h0, 64'h0, 2'd3});
    chk("R3", "gaps cleared", srr1_o, 64'd0);
    check_vec('{2'd2, 64'h0, 64'h0000_0000_783F_0000, 64'h0, 64'h0, 2'd3});
    chk("R5", "gaps kept", msr_o, 64'h0000_0000_783F_0000);

    // random mix
    for (int i = 0; i < 200; i++) begin
      v.op   = 2'($urandom_range(0, 3));
      v.cia  = {$urandom, $urandom};
      v.msr  = {$urandom, $urandom};
      v.srr0 = {$urandom, $urandom};
      v.srr1 = {$urandom, $urandom};
      v.ctx  = 2'($urandom);
      if (i % 7 == 0) v.msr[34:32] = 3'b010;
      if (i % 5 == 0) v.srr1[34:32] = 3'b000;
      check_vec(v);
    end

    summary();
  end

endmodule